// File: doc/BRIEF.md
# Error Pin Controller with Hold-Time Counter

This block drives the active-low error output of a safety error-signalling unit. Error events arrive as one-cycle pulses on three channel groups. Every group records its events in sticky status flags, and those flags are cleared by writing ones. A group 1 channel pulls the pin low only when its pin-action enable bit is set. Every channel of groups 2 and 3 always pulls the pin low.

Once low, the pin stays low for at least `LOW_CYCLES` clock cycles. It returns high only when that hold time has run out and a release request is pending. A release request is made by writing a key to the key register. The request is sticky. It survives later failures and may even be written while the pin is still high. In either case the pin rises by itself one hold time after the latest failure. A second key value forces the pin low for testing, and a third key ends that forced state.

A simple write port (enable, address, data) reaches the key register, the enable set register, the enable clear register and the three status clear registers.

Top module: `errpin_ctrl`

## Requirements
- R1: After a synchronous reset, the outputs are as follows: `err_n` is 1, every status flag is 0 and every group 1 pin-action enable is 0. No release request is pending and the counter is idle.
- R2: An event on a channel with pin action drives `err_n` to 0 after the next clock edge. A release key (value 0x5 in `wr_data[3:0]` at address 0) written d cycles after the failure edge (d ≥ 1) ends the low period after exactly max(`LOW_CYCLES`, d+1) cycles.
- R3: A pin-action event while `err_n` is 0 restarts the hold time from zero at that edge.
- R4: A release key written between two failures stays pending. The pin rises `LOW_CYCLES` cycles after the second failure with no further key write.
- R5: A release key written while `err_n` is 1 is remembered. The next failure holds the pin low for exactly `LOW_CYCLES` cycles, after which it rises by itself.
- R6: The pending release is consumed when the pin rises. A later failure keeps `err_n` at 0 indefinitely until a new 0x5 key write. After that write the pin rises one cycle later, because the hold time has already run out.
- R7: Key 0xA forces `err_n` to 0 when it is 1, and the pin then stays low even with a release pending. Key 0x0 ends the forcing. Key 0xA written while `err_n` is 0 has no effect.
- R8: A group 1 channel i affects the pin only while enable bit i is set. Any event in group 2 or group 3 always affects the pin.
- R9: Writing ones to address 1 sets the matching group 1 enable bits, and writing ones to address 2 clears them. Bits written as zero are unchanged.
- R10: An event sets the channel's status flag whether or not it has pin action. Writing a one to the flag's bit at address 3 (group 1), 4 (group 2) or 5 (group 3) clears that flag. A set and a clear in the same cycle leave the flag set.
- R11: Key values other than 0x5, 0xA and 0x0 change nothing. They neither release a low pin nor lower a high one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| g1_evt | input | G1_CH | Group 1 error event pulses |
| g2_evt | input | G2_CH | Group 2 error event pulses |
| g3_evt | input | G3_CH | Group 3 error event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| err_n | output | 1 | Active-low error pin |
| g1_stat | output | G1_CH | Group 1 status flags |
| g2_stat | output | G2_CH | Group 2 status flags |
| g3_stat | output | G3_CH | Group 3 status flags |
| g1_pin_en | output | G1_CH | Group 1 pin-action enables |

## Verification
The hardest situations to reach are those in which the release request and the failures interleave in time. These are a key written before a failure, a key written between two failures, and a key written after the hold time has already run out. The bench sweeps the key write delay over every cycle from 1 to `LOW_CYCLES`+3 after a failure and compares each measured low period with max(`LOW_CYCLES`, d+1). It then builds the between-failures and key-while-high sequences explicitly. A full cross of enable bit against event channel in group 1 covers the masking.

// File: rtl/errpin_pkg.sv
// Package: shared register addresses and key codes of the error pin controller.
package errpin_pkg;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_KEY     = 3'd0;
    localparam logic [AW-1:0] A_PEN_SET = 3'd1;
    localparam logic [AW-1:0] A_PEN_CLR = 3'd2;
    localparam logic [AW-1:0] A_G1_CLR  = 3'd3;
    localparam logic [AW-1:0] A_G2_CLR  = 3'd4;
    localparam logic [AW-1:0] A_G3_CLR  = 3'd5;

    typedef enum logic [3:0] {
        KEY_NORMAL  = 4'h0,
        KEY_RELEASE = 4'h5,
        KEY_FORCE   = 4'hA
    } key_e;
endpackage

// File: rtl/errpin_cfg.sv
// errpin_cfg: owns the group 1 pin-action enable register and decodes key writes
// into one-cycle command pulses. Assumes one write per cycle; unknown keys are dropped.
module errpin_cfg
    import errpin_pkg::*;
#(
    parameter int G1_CH = 8,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [G1_CH-1:0] pen_q,
    output logic             k_release,
    output logic             k_force,
    output logic             k_normal
);
    logic key_wr;
    logic [3:0] key_val;

    // Decode key register writes into command pulses.
    always_comb begin
        key_wr    = wr_en && (wr_addr == A_KEY);
        key_val   = wr_data[3:0];
        k_release = key_wr && (key_val == KEY_RELEASE);
        k_force   = key_wr && (key_val == KEY_FORCE);
        k_normal  = key_wr && (key_val == KEY_NORMAL);
    end

    // Pin-action enables: separate write-one-to-set and write-one-to-clear addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pen_q <= '0;
        else if (wr_en && wr_addr == A_PEN_SET)
            pen_q <= pen_q | wr_data[G1_CH-1:0];
        else if (wr_en && wr_addr == A_PEN_CLR)
            pen_q <= pen_q & ~wr_data[G1_CH-1:0];
    end

    // R9: a set write never lowers a bit, a clear write never raises one
    a_r9_set_only_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PEN_SET) |=> ((pen_q & $past(pen_q)) == $past(pen_q)));
    a_r9_clr_only_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PEN_CLR) |=> ((pen_q | $past(pen_q)) == $past(pen_q)));
endmodule

// File: rtl/errpin_status.sv
// errpin_status: sticky per-channel event flags for one group, cleared by writing
// ones to the group's clear address. A same-cycle event wins over its clear.
module errpin_status
    import errpin_pkg::*;
#(
    parameter int            W        = 4,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] CLR_ADDR = 3'd4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  evt,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [W-1:0]  stat_q
);
    logic [W-1:0] clr_mask;

    // Select the clear mask only on writes to this group's address.
    always_comb clr_mask = (wr_en && wr_addr == CLR_ADDR) ? wr_data[W-1:0] : '0;

    // Flag update: keep, clear on written ones, set on events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | evt;
    end

    // R10: every event is recorded at the next edge
    a_r10_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
    // R10: without a clear write, flags never drop
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CLR_ADDR) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: rtl/errpin_timer.sv
// errpin_timer: holds the error pin low for at least LOW_CYCLES cycles after the latest
// failure and lets it rise once the hold time is over and a sticky release is pending.
// Assumes LOW_CYCLES >= 2. The counter saturates at its last value while waiting.
module errpin_timer #(
    parameter int LOW_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail,
    input  logic k_release,
    input  logic k_force,
    input  logic k_normal,
    output logic pin_low_q
);
    localparam int CW = (LOW_CYCLES > 2) ? $clog2(LOW_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(LOW_CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          rel_q;
    logic          force_q;
    logic          start;
    logic          expired;
    logic          rise;

    // Combinational decisions: start of a low period and permission to rise.
    always_comb begin
        start   = fail || (k_force && !pin_low_q);
        expired = (cnt_q == LAST);
        rise    = pin_low_q && !start && expired && rel_q && !force_q;
    end

    // Pin state and hold-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_low_q <= 1'b0;
            cnt_q     <= '0;
        end else if (start) begin
            pin_low_q <= 1'b1;
            cnt_q     <= '0;
        end else if (rise) begin
            pin_low_q <= 1'b0;
            cnt_q     <= '0;
        end else if (pin_low_q && !expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Sticky release request: set by key, consumed when the pin rises.
    always_ff @(posedge clk) begin
        if (!rst_n)         rel_q <= 1'b0;
        else if (k_release) rel_q <= 1'b1;
        else if (rise)      rel_q <= 1'b0;
    end

    // Test forcing: armed only when the pin was high, ended by the normal key.
    always_ff @(posedge clk) begin
        if (!rst_n)                      force_q <= 1'b0;
        else if (k_force && !pin_low_q)  force_q <= 1'b1;
        else if (k_normal)               force_q <= 1'b0;
    end

    // R2: the pin rises only after a full hold time with a release pending
    a_r2_rise_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_low_q) |-> ($past(cnt_q) == LAST && $past(rel_q)));
    // R3: a failure always leaves the pin low with a fresh count
    a_r3_fail_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> (pin_low_q && cnt_q == '0));
    // R6: the release is consumed by the rise unless re-written on that edge
    a_r6_release_consumed: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pin_low_q) |-> (!rel_q || $past(k_release)));
    // R7: while forcing is armed the pin is low
    a_r7_force_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        force_q |-> pin_low_q);
endmodule

// File: rtl/errpin_ctrl.sv
// errpin_ctrl: top of the error pin controller. Combines three groups of event
// inputs, group 1 pin-action masking, status flags, key decoding and the hold timer.
// Assumes every group width is at most DW and LOW_CYCLES >= 2.
module errpin_ctrl
    import errpin_pkg::*;
#(
    parameter int G1_CH      = 8,
    parameter int G2_CH      = 4,
    parameter int G3_CH      = 4,
    parameter int DW         = 8,
    parameter int LOW_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [G1_CH-1:0] g1_evt,
    input  logic [G2_CH-1:0] g2_evt,
    input  logic [G3_CH-1:0] g3_evt,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic             err_n,
    output logic [G1_CH-1:0] g1_stat,
    output logic [G2_CH-1:0] g2_stat,
    output logic [G3_CH-1:0] g3_stat,
    output logic [G1_CH-1:0] g1_pin_en
);
    logic k_release, k_force, k_normal;
    logic fail;
    logic pin_low;

    errpin_cfg #(.G1_CH(G1_CH), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pen_q(g1_pin_en), .k_release(k_release), .k_force(k_force), .k_normal(k_normal)
    );

    errpin_status #(.W(G1_CH), .DW(DW), .CLR_ADDR(A_G1_CLR)) u_st1 (
        .clk(clk), .rst_n(rst_n), .evt(g1_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_q(g1_stat)
    );
    errpin_status #(.W(G2_CH), .DW(DW), .CLR_ADDR(A_G2_CLR)) u_st2 (
        .clk(clk), .rst_n(rst_n), .evt(g2_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_q(g2_stat)
    );
    errpin_status #(.W(G3_CH), .DW(DW), .CLR_ADDR(A_G3_CLR)) u_st3 (
        .clk(clk), .rst_n(rst_n), .evt(g3_evt), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .stat_q(g3_stat)
    );

    // Failure: masked group 1 events plus every group 2 and group 3 event.
    always_comb fail = (|(g1_evt & g1_pin_en)) || (|g2_evt) || (|g3_evt);

    errpin_timer #(.LOW_CYCLES(LOW_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .fail(fail), .k_release(k_release),
        .k_force(k_force), .k_normal(k_normal), .pin_low_q(pin_low)
    );

    // Pin output is the inverted registered low state.
    always_comb err_n = ~pin_low;

    // R8: a group 1 event without its enable, and no other event, never lowers a high pin
    a_r8_masked_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (err_n && (g1_evt & g1_pin_en) == '0 && g2_evt == '0 && g3_evt == '0
         && !(wr_en && wr_addr == A_KEY)) |=> err_n);
    // R1: reset leaves the pin high
    a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> err_n);
endmodule

// File: tb/tb_errpin_ctrl.sv
`timescale 1ns/100ps
module tb_errpin_ctrl;
    localparam int G1 = 8, G2 = 4, G3 = 4, DW = 8, LOW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [G1-1:0] g1_evt = '0;
    logic [G2-1:0] g2_evt = '0;
    logic [G3-1:0] g3_evt = '0;
    logic wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic err_n;
    logic [G1-1:0] g1_stat, g1_pin_en;
    logic [G2-1:0] g2_stat;
    logic [G3-1:0] g3_stat;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    errpin_ctrl #(.G1_CH(G1), .G2_CH(G2), .G3_CH(G3), .DW(DW), .LOW_CYCLES(LOW)) dut (
        .clk(clk), .rst_n(rst_n), .g1_evt(g1_evt), .g2_evt(g2_evt), .g3_evt(g3_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .err_n(err_n),
        .g1_stat(g1_stat), .g2_stat(g2_stat), .g3_stat(g3_stat), .g1_pin_en(g1_pin_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic fail_g2();
        g2_evt = 4'b0010;
        step();
        g2_evt = '0;
    endtask

    // Counts cycles until err_n is high, starting from count n.
    task automatic measure(inout int n, input int lim);
        while (err_n == 1'b0 && n < lim) begin
            step();
            n++;
        end
    endtask

    task automatic clear_all();
        wr(3'd3, '1); wr(3'd4, '1); wr(3'd5, '1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 err_n", err_n, 1);
        chk("R1 g1_stat", g1_stat, 0);
        chk("R1 g2_stat", g2_stat, 0);
        chk("R1 g3_stat", g3_stat, 0);
        chk("R1 g1_pin_en", g1_pin_en, 0);

        // R2 sweep of the release delay d
        for (int d = 1; d <= LOW + 3; d++) begin
            fail_g2();
            n = 0;
            chk("R2 low after fail", err_n, 0);
            repeat (d - 1) begin step(); n++; end
            wr(3'd0, 8'h05); n++;
            measure(n, 4 * LOW);
            chk("R2 low duration", n, (d + 1 > LOW) ? d + 1 : LOW);
            step();
        end

        // R3/R4: release between two failures, refail at cycle 5
        fail_g2(); n = 0;
        step(); n++;
        wr(3'd0, 8'h05); n++;
        step(); n++; step(); n++;
        fail_g2(); n++;
        chk("R3 still low at refail", err_n, 0);
        measure(n, 6 * LOW);
        chk("R4 pending release across failures", n, 5 + LOW);
        step();

        // R5: release written while high
        wr(3'd0, 8'h05);
        chk("R5 key while high keeps pin high", err_n, 1);
        repeat (3) step();
        fail_g2(); n = 0;
        measure(n, 4 * LOW);
        chk("R5 remembered release", n, LOW);

        // R6: consumed; next failure holds low until a new key
        step();
        fail_g2();
        repeat (3 * LOW) step();
        chk("R6 held without key", err_n, 0);
        wr(3'd0, 8'h05);
        chk("R6 not yet released", err_n, 0);
        step();
        chk("R6 released one cycle after key", err_n, 1);

        // R11: ignored keys
        wr(3'd0, 8'h03);
        chk("R11 key3 keeps high", err_n, 1);
        fail_g2();
        wr(3'd0, 8'h07);
        wr(3'd0, 8'h0C);
        repeat (2 * LOW) step();
        chk("R11 key7/keyC no release", err_n, 0);
        wr(3'd0, 8'h05); step();
        chk("R11 release after real key", err_n, 1);

        // R7: force from high
        wr(3'd0, 8'h0A);
        chk("R7 force lowers pin", err_n, 0);
        wr(3'd0, 8'h05);
        repeat (2 * LOW) step();
        chk("R7 forced stays low", err_n, 0);
        wr(3'd0, 8'h00);
        step();
        chk("R7 normal key ends force", err_n, 1);
        // R7: force while low has no effect
        fail_g2(); n = 0;
        wr(3'd0, 8'h0A); n++;
        wr(3'd0, 8'h05); n++;
        measure(n, 4 * LOW);
        chk("R7 force while low ignored", n, LOW);
        step();
        clear_all();

        // R9: enable set and clear
        wr(3'd1, 8'h0F);
        chk("R9 set", g1_pin_en, 8'h0F);
        wr(3'd2, 8'h05);
        chk("R9 clear", g1_pin_en, 8'h0A);
        wr(3'd2, 8'hFF);
        chk("R9 clear all", g1_pin_en, 0);

        // R8/R10: cross of enable bit and event channel in group 1
        for (int i = 0; i < G1; i++) begin
            wr(3'd1, 8'(1 << i));
            for (int j = 0; j < G1; j++) begin
                g1_evt = 8'(1 << j);
                step();
                g1_evt = '0;
                chk("R10 g1 status set", g1_stat, 1 << j);
                chk("R8 g1 masking", err_n, (i == j) ? 0 : 1);
                if (i == j) begin
                    wr(3'd0, 8'h05);
                    repeat (LOW) step();
                    chk("R8 g1 release", err_n, 1);
                end
                wr(3'd3, 8'(1 << j));
                chk("R10 g1 status cleared", g1_stat, 0);
            end
            wr(3'd2, 8'(1 << i));
        end

        // R8/R10: group 3 always acts; W1C is per bit
        g3_evt = 4'b0101; step(); g3_evt = '0;
        chk("R8 g3 always acts", err_n, 0);
        chk("R10 g3 status", g3_stat, 5);
        wr(3'd5, 8'h04);
        chk("R10 g3 partial clear", g3_stat, 1);
        g2_evt = 4'b1000; wr(3'd4, 8'h08);
        chk("R10 set wins over clear", g2_stat, 8);
        g2_evt = '0;
        wr(3'd0, 8'h05);
        repeat (LOW) step();
        chk("R2 release after g3 failure", err_n, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule